// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor read and write a small bank of byte-wide registers over a four-wire serial link. The link has an active-low select, a serial clock that idles low, a data input and a data output. The data output has a separate enable so that a pad can release the line. Every frame is full duplex. While the host shifts in an address, a read-only flag and a data byte, the block shifts out a status byte and then the current contents of the addressed register.

The serial pins are oversampled by the system clock. Input bits are taken on falling serial-clock edges, and output bits advance on rising edges. A write takes effect only when the select is released after a frame of exactly the right length. A frame with the read-only flag set returns the register without changing it. A frame of any other length is dropped and is reported in the status byte of the next frame.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register reads 0x00 and the status byte is 0x00 (error flag clear, last address 0).
- R2: `spi_sdo_oe` is low while the select is high, is high during a frame, and drops within a few clocks of the select rising.
- R3: The input frame is 16 bits, MSB first: bits 15..9 are the address, bit 8 is the read-only flag (1 = read only) and bits 7..0 are the write data. The output frame is also MSB first.
- R4: A write frame with the flag at 0 updates the addressed register only when the select rises after exactly 16 falling clock edges. The new value is returned by the next frame to that address.
- R5: A frame with the read-only flag at 1 leaves every register unchanged, and it still returns the register contents.
- R6: A frame with fewer or more than 16 falling edges changes no register and sets the error flag (status bit 7).
- R7: Output bits 15..8 form a status byte that is captured when the select falls: bit 7 is the error flag and bits 6..0 are the address of the last well-formed frame. A well-formed frame clears the error flag and records its address.
- R8: Output bits 7..0 hold the contents of the addressed register as they stood before this frame's own write.
- R9: Addresses at or above `NUM_REGS` read as 0x00, and writes to them are dropped.
- R10: Serial clock edges while the select is high are ignored and do not disturb the next frame.
- R11: The data output changes only on a falling select (first status bit) or on a rising serial clock, never on a falling one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo`; the pad floats when low |

## Verification
The bench uses the default `NUM_REGS` of 16 against a 7-bit address space. This puts addresses above the bank, such as 100, in reach, so the read-as-zero and dropped-write behaviour can be tried. The default two-stage pin synchroniser is used with six system clocks per serial half period. This leaves room to see that the output holds through falling edges and moves after rising ones. Frames of 10 and 17 bits, clock toggles with the select high, and a reset in the middle of the run cover the error flag and the return to the reset contents.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int STAT_W  = ADDR_W + 1;
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    // Synchronised pin events, each valid for one system clock
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } spi_evt_t;

    // Status byte returned at the start of every frame
    typedef struct packed {
        logic              err;
        logic [ADDR_W-1:0] last_addr;
    } status_t;

    // Result of one frame, presented for one clock when the select rises
    typedef struct packed {
        logic              valid;
        logic              good;
        logic              ro;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_res_t;

    function automatic logic len_ok(input logic [CNT_W-1:0] falls);
        return falls == CNT_W'(FRAME_W);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     csn_pin,
    input  logic     sck_pin,
    input  logic     mosi_pin,
    output spi_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] csn_s;
    logic [SYNC_STAGES-1:0] sck_s;
    logic [SYNC_STAGES-1:0] mosi_s;
    logic                   csn_d;
    logic                   sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_s  <= '1;
            sck_s  <= '0;
            mosi_s <= '0;
            csn_d  <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            csn_s  <= {csn_s[SYNC_STAGES-2:0], csn_pin};
            sck_s  <= {sck_s[SYNC_STAGES-2:0], sck_pin};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi_pin};
            csn_d  <= csn_s[LAST];
            sck_d  <= sck_s[LAST];
        end
    end

    always_comb begin
        evt.cs_fall  = csn_d & ~csn_s[LAST];
        evt.cs_rise  = ~csn_d & csn_s[LAST];
        evt.sck_rise = ~sck_d & sck_s[LAST];
        evt.sck_fall = sck_d & ~sck_s[LAST];
        evt.mosi     = mosi_s[LAST];
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  status_t           status,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output frame_res_t        res,
    output logic              sdo,
    output logic              sdo_oe
);

    logic               active;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx;
    logic [ADDR_W-1:0]  addr_q;
    status_t            stat_q;
    logic               sdo_q;
    frame_res_t         res_q;

    logic [FRAME_W-1:0] tx_word;
    logic [FRAME_W-1:0] tx_sh;
    logic               out_bit;

    // Next output bit: index follows the count of falling edges seen
    always_comb begin
        tx_word = {stat_q, rd_data};
        tx_sh   = tx_word << bit_cnt;
        out_bit = (bit_cnt < CNT_W'(FRAME_W)) ? tx_sh[FRAME_W-1] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            rx      <= '0;
            addr_q  <= '0;
            stat_q  <= '0;
            sdo_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            res_q.valid <= 1'b0;
            if (evt.cs_fall) begin
                active  <= 1'b1;
                bit_cnt <= '0;
                rx      <= '0;
                stat_q  <= status;
                sdo_q   <= status.err;
            end else if (evt.cs_rise) begin
                active <= 1'b0;
                if (active) begin
                    res_q.valid <= 1'b1;
                    res_q.good  <= len_ok(bit_cnt);
                    res_q.ro    <= rx[DATA_W];
                    res_q.addr  <= rx[FRAME_W-1 -: ADDR_W];
                    res_q.data  <= rx[DATA_W-1:0];
                end
            end else if (active) begin
                if (evt.sck_fall) begin
                    rx <= {rx[FRAME_W-2:0], evt.mosi};
                    if (bit_cnt != CNT_W'(FRAME_W + 1)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                        addr_q <= {rx[ADDR_W-2:0], evt.mosi};
                    end
                end
                if (evt.sck_rise) begin
                    sdo_q <= out_bit;
                end
            end
        end
    end

    assign rd_addr = addr_q;
    assign res     = res_q;
    assign sdo     = sdo_q;
    assign sdo_oe  = active;

    // R2: output released after the select rises
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (rst)
        evt.cs_rise |=> !sdo_oe);

    // R7: first output bit is the status error flag captured at select fall
    assert_status_first_R7: assert property (@(posedge clk) disable iff (rst)
        evt.cs_fall |=> (sdo_oe && sdo == $past(status.err)));

    // R11: output moves only on a rising serial clock or a falling select
    assert_sdo_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!evt.sck_rise && !evt.cs_fall) |=> $stable(sdo));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int          IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < LIMIT) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

    // R4: contents move only on a commit
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    // R9: commits beyond the bank are dropped
    assert_oob_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, wr_addr} >= LIMIT)) |=> $stable(regs));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_sdi,
    output logic spi_sdo,
    output logic spi_sdo_oe
);

    spi_evt_t          evt;
    frame_res_t        res;
    status_t           stat_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .csn_pin  (spi_csn),
        .sck_pin  (spi_sck),
        .mosi_pin (spi_sdi),
        .evt      (evt)
    );

    spi_frame_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .status  (stat_q),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .res     (res),
        .sdo     (spi_sdo),
        .sdo_oe  (spi_sdo_oe)
    );

    assign wr_en = res.valid && res.good && !res.ro;

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (res.addr),
        .wr_data (res.data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (res.valid) begin
            if (res.good) begin
                stat_q.err       <= 1'b0;
                stat_q.last_addr <= res.addr;
            end else begin
                stat_q.err <= 1'b1;
            end
        end
    end

    // R6: a badly sized frame raises the error flag
    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.good) |=> stat_q.err);

    // R7: a well-formed frame clears the flag and records its address
    assert_err_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.good) |=> (!stat_q.err && stat_q.last_addr == $past(res.addr)));

endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;

    logic clk = 1'b0;
    logic rst;
    logic spi_csn;
    logic spi_sck;
    logic spi_sdi;
    logic spi_sdo;
    logic spi_sdo_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk        (clk),
        .rst        (rst),
        .spi_csn    (spi_csn),
        .spi_sck    (spi_sck),
        .spi_sdi    (spi_sdi),
        .spi_sdo    (spi_sdo),
        .spi_sdo_oe (spi_sdo_oe)
    );

    // [31:16] frame in {addr, ro, data}; [15:0] expected frame out {status, data}
    localparam logic [31:0] VECS [8] = '{
        {7'd3,   1'b0, 8'hA5, 16'h0000},   // R1 R4: reset status and data
        {7'd3,   1'b1, 8'hFF, 16'h03A5},   // R5: read only
        {7'd3,   1'b0, 8'h5A, 16'h03A5},   // R8: old value returned
        {7'd15,  1'b0, 8'h81, 16'h0300},
        {7'd3,   1'b1, 8'h00, 16'h0F5A},   // R7: last address 15
        {7'd100, 1'b0, 8'h77, 16'h0300},   // R9: write beyond bank
        {7'd100, 1'b1, 8'h00, 16'h6400},   // R9: reads zero
        {7'd15,  1'b1, 8'h00, 16'h6481}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic spi_xfer(input int nbits, input logic [31:0] din,
                            output logic [15:0] dout, output logic oe_mid,
                            output logic hold_ok);
        logic prev;
        dout    = '0;
        hold_ok = 1'b1;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (8) @(negedge clk);
        oe_mid = spi_sdo_oe;
        prev   = spi_sdo;
        for (int i = 0; i < nbits; i++) begin
            if (spi_sdo !== prev) hold_ok = 1'b0;
            spi_sdi = din[nbits-1-i];
            spi_sck = 1'b1;
            repeat (6) @(negedge clk);
            if (i < 16) dout[15-i] = spi_sdo;
            prev = spi_sdo;
            spi_sck = 1'b0;
            repeat (6) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame16(input logic [15:0] fin, input logic [15:0] exp, input string tag);
        logic [15:0] dout;
        logic oe_mid, hold_ok;
        spi_xfer(16, {16'h0, fin}, dout, oe_mid, hold_ok);
        check(tag, dout, exp);
        check("R11 output held across falling edges", {15'h0, hold_ok}, 16'h0001);
        check("R2 output enabled in frame", {15'h0, oe_mid}, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] dout;
        logic oe_mid, hold_ok;
        rst = 1'b1; spi_csn = 1'b1; spi_sck = 1'b0; spi_sdi = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 R2 output disabled after reset", {15'h0, spi_sdo_oe}, 16'h0000);

        for (int v = 0; v < 8; v++) begin
            frame16(VECS[v][31:16], VECS[v][15:0], "R3 R8 table vector");
        end
        check("R2 output released after frame", {15'h0, spi_sdo_oe}, 16'h0000);

        // R6: short frame of 10 bits writing addr 3
        spi_xfer(10, {16'h0, 7'd3, 1'b0, 8'h00} >> 6, dout, oe_mid, hold_ok);
        frame16({7'd3, 1'b1, 8'h00}, 16'h8F5A, "R6 short frame flagged, reg kept");

        // R6: long frame of 17 bits writing addr 3
        spi_xfer(17, {15'h0, 7'd3, 1'b0, 8'h11, 1'b0}, dout, oe_mid, hold_ok);
        frame16({7'd3, 1'b1, 8'h00}, 16'h835A, "R6 long frame flagged, reg kept");

        // R10: clock toggles with select high
        for (int k = 0; k < 10; k++) begin
            spi_sck = 1'b1; repeat (6) @(negedge clk);
            spi_sck = 1'b0; repeat (6) @(negedge clk);
        end
        frame16({7'd3, 1'b0, 8'hC3}, 16'h035A, "R10 frame after idle clocks");
        frame16({7'd3, 1'b1, 8'h00}, 16'h03C3, "R4 R10 write committed");

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        frame16({7'd3, 1'b1, 8'h00}, 16'h0000, "R1 registers cleared by reset");
        frame16({7'd15, 1'b1, 8'h00}, 16'h0300, "R1 R7 status after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule